// File: doc/BRIEF.md
# Lockable Register File Controller

This block is the byte-addressed register file of an elapsed-time and event recorder. It sits behind a simple byte port: a start strobe opens a transfer, the first byte written after the strobe loads a 5-bit address pointer, and every later byte written or read uses the pointer's location and then moves the pointer up by one. The file holds a configuration byte, a 32-bit alarm value and ten bytes of user memory. It also shows the external elapsed-time and event counters as bytes that can be read and, when they are not locked, written.

Three command locations accept double-write sequences. Writing the same magic byte to one of them in two consecutive data writes performs a one-way action:
- setting a permanent write-disable that freezes the alarm and the counters,
- setting a permanent memory lock that freezes the user bytes,
- a one-time counter reset, which also makes the configuration byte read-only.

A dirty flag notes any stored value that actually changes while an event is active. When the event ends, the block raises a one-cycle save request for the external nonvolatile store.

Top module: `lockreg_ctrl`

## Requirements
- R1: After `start_i`, the first `wr_i` byte loads its low 5 bits into the pointer and stores nothing. Each later `wr_i` or `rd_i` acts at the pointer and then increments it modulo 32. `rd_data_o` always shows the byte at the pointer.
- R2: The configuration byte at 00h reads, from bit 7 down to bit 0: constant 0, `af_i`, write-disable flag, memory-lock flag, alarm select (`aos_o`), reset enable, alarm polarity (`ap_o`), `evc_i[16]`. Only bits 3, 2 and 1 are writable. All three are 0 after `rst_ni`.
- R3: A double-write command fires only when its two matching data writes are consecutive. Any other data write in between cancels it. Pointer-load bytes and reads do not cancel it.
- R4: Writing AAh twice to 1Eh sets the write-disable flag for good. After that, writes to the alarm bytes leave them unchanged and writes to the counter bytes raise no `cnt_wr_o`.
- R5: Writing F0h twice to 1Fh sets the memory-lock flag for good. After that, writes to the user bytes leave them unchanged.
- R6: Writing 55h twice to 1Dh while reset enable is 1 has three effects. It clears reset enable, it makes the configuration byte read-only, and it raises `clr_cnt_o` for exactly one cycle, starting the cycle after the second write. When reset enable is 0 the command does nothing.
- R7: Any reset command after the first effective one is ignored and produces no `clr_cnt_o`.
- R8: Bytes 05h–08h read `etc_i` least significant byte first. Bytes 09h–0Ah read `evc_i[15:0]` least significant byte first. While write-disable is clear, a data write to 05h–0Ah drives `cnt_wr_o`=1 in its own cycle, with `cnt_wr_idx_o` = address − 5 and `cnt_wr_data_o` = the written byte.
- R9: `save_req_o` pulses for one cycle, one cycle after `event_active_i` falls, if and only if some stored byte or flag changed value during the event. A write of an identical value, or a write made outside an event, causes no pulse.
- R10: The alarm occupies 01h–04h least significant byte first and appears on `alarm_o`. User memory occupies 0Bh–14h. Every other address reads 00h.
- R11: A reset command issued while write-disable is set still clears reset enable and makes the configuration byte read-only, but raises no `clr_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a transfer; next written byte loads the pointer |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe, advances the pointer |
| wdata_i | input | 8 | Write byte |
| rd_data_o | output | 8 | Byte at the pointer |
| event_active_i | input | 1 | Event in progress |
| af_i | input | 1 | Alarm flag from the compare logic |
| etc_i | input | 32 | Elapsed-time counter value |
| evc_i | input | 17 | Event counter value |
| alarm_o | output | 32 | Alarm value |
| aos_o | output | 1 | Alarm output select bit |
| ap_o | output | 1 | Alarm polarity bit |
| wd_flag_o | output | 1 | Write-disable lock flag |
| wmd_flag_o | output | 1 | User memory lock flag |
| clr_cnt_o | output | 1 | One-cycle counter clear strobe |
| cnt_wr_o | output | 1 | Counter byte write strobe |
| cnt_wr_idx_o | output | 3 | Counter byte index (0–3 time, 4–5 events) |
| cnt_wr_data_o | output | 8 | Counter byte write data |
| save_req_o | output | 1 | One-cycle save request at event end |

## Verification
The command decoder is driven with four kinds of sequence:
- two clean consecutive magic writes,
- a pair split by an unrelated data write,
- a pair split only by a new transfer's pointer byte,
- a pair that uses a wrong magic byte.

Together these separate "consecutive data writes" from "any two writes". The reset command is tried three ways: with the enable cleared, with it set, and with write-disable already set. Each case shows whether the clear strobe, the enable bit and the configuration lock are tied together or independent. Writes inside an event are tried with an identical value, with a changed value, and outside the event, which distinguishes "changed" from "written".

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int ADDR_W = 5;
  localparam int ALM_N  = 4;
  localparam int ETC_N  = 4;
  localparam int EVC_N  = 2;
  localparam int EVC_W  = 17;
  localparam int USR_N  = 10;
  localparam int NUM_CMD = 3;

  localparam int ALM_IW = $clog2(ALM_N);
  localparam int ETC_IW = $clog2(ETC_N);
  localparam int EVC_IW = $clog2(EVC_N);
  localparam int USR_IW = $clog2(USR_N);
  localparam int CNT_IW = $clog2(ETC_N + EVC_N);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [7:0] byte_t;

  localparam addr_t A_CFG     = addr_t'(0);
  localparam addr_t A_ALM     = addr_t'(1);
  localparam addr_t A_ALM_END = addr_t'(1 + ALM_N);
  localparam addr_t A_ETC     = A_ALM_END;
  localparam addr_t A_ETC_END = addr_t'(1 + ALM_N + ETC_N);
  localparam addr_t A_EVC     = A_ETC_END;
  localparam addr_t A_EVC_END = addr_t'(1 + ALM_N + ETC_N + EVC_N);
  localparam addr_t A_USR     = A_EVC_END;
  localparam addr_t A_USR_END = addr_t'(1 + ALM_N + ETC_N + EVC_N + USR_N);
  localparam addr_t A_RST     = addr_t'(5'h1D);
  localparam addr_t A_WD      = addr_t'(5'h1E);
  localparam addr_t A_WMD     = addr_t'(5'h1F);

  typedef enum int {CMD_RST = 0, CMD_WD = 1, CMD_WMD = 2} cmd_e;

  localparam addr_t CMD_ADDR  [NUM_CMD] = '{A_RST, A_WD, A_WMD};
  localparam byte_t CMD_MAGIC [NUM_CMD] = '{8'h55, 8'hAA, 8'hF0};
endpackage

// File: rtl/lrf_ptr.sv
module lrf_ptr
  import lrf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  wr_i,
  input  logic  rd_i,
  input  addr_t wptr_i,
  output addr_t ptr_o,
  output logic  data_wr_o
);
  logic  need_ptr_q;
  addr_t ptr_q;
  logic  ptr_wr;

  assign ptr_wr    = wr_i & need_ptr_q;
  assign data_wr_o = wr_i & ~need_ptr_q;
  assign ptr_o     = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      need_ptr_q <= 1'b1;
      ptr_q      <= '0;
    end else begin
      if (start_i)   need_ptr_q <= 1'b1;
      else if (wr_i) need_ptr_q <= 1'b0;
      if (ptr_wr)                      ptr_q <= wptr_i;
      else if (data_wr_o || rd_i)      ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_PTR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr |=> ptr_q == $past(wptr_i)) else $error("ptr load"); // R1
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_o || (rd_i && !ptr_wr)) |=> ptr_q == addr_t'($past(ptr_q) + 1'b1)) else $error("ptr step"); // R1
endmodule

// File: rtl/lrf_cmd.sv
module lrf_cmd
  import lrf_pkg::*;
#(
  parameter addr_t ADDR  = addr_t'(0),
  parameter byte_t MAGIC = 8'h00
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  data_wr_i,
  input  addr_t addr_i,
  input  byte_t wdata_i,
  output logic  fire_o
);
  logic armed_q;
  logic hit;

  assign hit    = (addr_i == ADDR) && (wdata_i == MAGIC);
  assign fire_o = data_wr_i & hit & armed_q;

  // any data write re-evaluates the half sequence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (data_wr_i) armed_q <= hit & ~armed_q;
  end
endmodule

// File: rtl/lrf_store.sv
module lrf_store
  import lrf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_wr_i,
  input  addr_t              addr_i,
  input  byte_t              wdata_i,
  input  logic               cfg_ro_i,
  input  logic               wd_i,
  input  logic               wmd_i,
  input  logic               rst_eff_i,
  input  logic               lock_evt_i,
  input  logic               event_active_i,
  output logic               aos_o,
  output logic               re_o,
  output logic               ap_o,
  output logic [ALM_N*8-1:0] alm_o,
  output logic [USR_N*8-1:0] usr_o,
  output logic               save_o
);
  logic [ALM_N*8-1:0] alm_q;
  logic [USR_N*8-1:0] usr_q;
  logic aos_q, re_q, ap_q;
  logic ev_q, dirty_q, save_q;
  logic alm_we, usr_we, cfg_we, chg;
  logic [ALM_IW+2:0] alm_sel;
  logic [USR_IW+2:0] usr_sel;

  assign alm_sel = {ALM_IW'(addr_i - A_ALM), 3'b000};
  assign usr_sel = {USR_IW'(addr_i - A_USR), 3'b000};
  assign alm_we  = data_wr_i && addr_i >= A_ALM && addr_i < A_ALM_END && !wd_i;
  assign usr_we  = data_wr_i && addr_i >= A_USR && addr_i < A_USR_END && !wmd_i;
  assign cfg_we  = data_wr_i && addr_i == A_CFG && !cfg_ro_i;

  always_comb begin
    chg = lock_evt_i;
    if (alm_we && alm_q[alm_sel +: 8] != wdata_i) chg = 1'b1;
    if (usr_we && usr_q[usr_sel +: 8] != wdata_i) chg = 1'b1;
    if (cfg_we && {aos_q, re_q, ap_q} != wdata_i[3:1]) chg = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= '0;
      usr_q <= '0;
      aos_q <= 1'b0;
      re_q  <= 1'b0;
      ap_q  <= 1'b0;
    end else begin
      if (alm_we) alm_q[alm_sel +: 8] <= wdata_i;
      if (usr_we) usr_q[usr_sel +: 8] <= wdata_i;
      if (cfg_we) {aos_q, re_q, ap_q} <= wdata_i[3:1];
      if (rst_eff_i) re_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q    <= 1'b0;
      dirty_q <= 1'b0;
      save_q  <= 1'b0;
    end else begin
      ev_q   <= event_active_i;
      save_q <= ev_q & ~event_active_i & dirty_q;
      if (ev_q && !event_active_i)   dirty_q <= 1'b0;
      else if (event_active_i && chg) dirty_q <= 1'b1;
    end
  end

  assign aos_o  = aos_q;
  assign re_o   = re_q;
  assign ap_o   = ap_q;
  assign alm_o  = alm_q;
  assign usr_o  = usr_q;
  assign save_o = save_q;

  AST_CFG_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ro_i |=> $stable(aos_q) && $stable(ap_q)) else $error("cfg ro"); // R6
  AST_ALM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_i |=> $stable(alm_q)) else $error("alarm lock"); // R4
  AST_USR_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wmd_i |=> $stable(usr_q)) else $error("user lock"); // R5
  AST_SAVE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_q |=> !save_q) else $error("save pulse"); // R9
endmodule

// File: rtl/lockreg_ctrl.sv
module lockreg_ctrl
  import lrf_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rd_data_o,
  input  logic                   event_active_i,
  input  logic                   af_i,
  input  logic [ETC_N*8-1:0]     etc_i,
  input  logic [EVC_W-1:0]       evc_i,
  output logic [ALM_N*8-1:0]     alarm_o,
  output logic                   aos_o,
  output logic                   ap_o,
  output logic                   wd_flag_o,
  output logic                   wmd_flag_o,
  output logic                   clr_cnt_o,
  output logic                   cnt_wr_o,
  output logic [CNT_IW-1:0]      cnt_wr_idx_o,
  output logic [7:0]             cnt_wr_data_o,
  output logic                   save_req_o
);
  addr_t ptr;
  logic  data_wr;
  logic [NUM_CMD-1:0] fire;
  logic  wd_q, wmd_q, rst_done_q, clr_q;
  logic  rst_eff, lock_evt;
  logic  aos, re, ap;
  logic [ALM_N*8-1:0] alm;
  logic [USR_N*8-1:0] usr;

  lrf_ptr u_ptr (
    .clk_i, .rst_ni, .start_i, .wr_i, .rd_i,
    .wptr_i    (wdata_i[ADDR_W-1:0]),
    .ptr_o     (ptr),
    .data_wr_o (data_wr)
  );

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    lrf_cmd #(.ADDR(CMD_ADDR[g]), .MAGIC(CMD_MAGIC[g])) u_cmd (
      .clk_i, .rst_ni,
      .data_wr_i (data_wr),
      .addr_i    (ptr),
      .wdata_i   (wdata_i),
      .fire_o    (fire[g])
    );
  end

  assign rst_eff  = fire[CMD_RST] & re & ~rst_done_q;
  assign lock_evt = rst_eff | (fire[CMD_WD] & ~wd_q) | (fire[CMD_WMD] & ~wmd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q       <= 1'b0;
      wmd_q      <= 1'b0;
      rst_done_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      if (fire[CMD_WD])  wd_q  <= 1'b1;
      if (fire[CMD_WMD]) wmd_q <= 1'b1;
      if (rst_eff)       rst_done_q <= 1'b1;
      clr_q <= rst_eff & ~wd_q;
    end
  end

  lrf_store u_store (
    .clk_i, .rst_ni,
    .data_wr_i      (data_wr),
    .addr_i         (ptr),
    .wdata_i        (wdata_i),
    .cfg_ro_i       (rst_done_q),
    .wd_i           (wd_q),
    .wmd_i          (wmd_q),
    .rst_eff_i      (rst_eff),
    .lock_evt_i     (lock_evt),
    .event_active_i (event_active_i),
    .aos_o          (aos),
    .re_o           (re),
    .ap_o           (ap),
    .alm_o          (alm),
    .usr_o          (usr),
    .save_o         (save_req_o)
  );

  always_comb begin
    rd_data_o = 8'h00;
    if (ptr == A_CFG)
      rd_data_o = {1'b0, af_i, wd_q, wmd_q, aos, re, ap, evc_i[EVC_W-1]};
    else if (ptr >= A_ALM && ptr < A_ALM_END)
      rd_data_o = alm[{ALM_IW'(ptr - A_ALM), 3'b000} +: 8];
    else if (ptr >= A_ETC && ptr < A_ETC_END)
      rd_data_o = etc_i[{ETC_IW'(ptr - A_ETC), 3'b000} +: 8];
    else if (ptr >= A_EVC && ptr < A_EVC_END)
      rd_data_o = evc_i[{EVC_IW'(ptr - A_EVC), 3'b000} +: 8];
    else if (ptr >= A_USR && ptr < A_USR_END)
      rd_data_o = usr[{USR_IW'(ptr - A_USR), 3'b000} +: 8];
  end

  assign cnt_wr_o      = data_wr && ptr >= A_ETC && ptr < A_EVC_END && !wd_q;
  assign cnt_wr_idx_o  = CNT_IW'(ptr - A_ETC);
  assign cnt_wr_data_o = wdata_i;

  assign alarm_o    = alm;
  assign aos_o      = aos;
  assign ap_o       = ap;
  assign wd_flag_o  = wd_q;
  assign wmd_flag_o = wmd_q;
  assign clr_cnt_o  = clr_q;

  AST_WD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q |=> wd_q) else $error("wd sticky"); // R4
  AST_WMD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wmd_q |=> wmd_q) else $error("wmd sticky"); // R5
  AST_WD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_q) |-> $past(data_wr && ptr == A_WD && wdata_i == 8'hAA)) else $error("wd cause"); // R4
  AST_RST_CLEARS_RE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_done_q) |-> !re) else $error("re clear"); // R6
  AST_CLR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_done_q && $past(rst_done_q)) |-> !clr_q) else $error("clr once"); // R7
  AST_CLR_WD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |-> !$past(wd_q)) else $error("clr under wd"); // R11
endmodule

// File: tb/lockreg_ctrl_bench.sv
module lockreg_ctrl_bench;
  localparam time CLK_T = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, wr = 0, rd = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic        ev = 0, af = 0;
  logic [31:0] etc = 0;
  logic [16:0] evc = 0;
  logic [31:0] alarm;
  logic        aos, ap, wd, wmd, clr, cnt_wr, save;
  logic [2:0]  cnt_idx;
  logic [7:0]  cnt_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  lockreg_ctrl u_lockreg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rd_data_o(rdata), .event_active_i(ev), .af_i(af),
    .etc_i(etc), .evc_i(evc), .alarm_o(alarm), .aos_o(aos), .ap_o(ap),
    .wd_flag_o(wd), .wmd_flag_o(wmd), .clr_cnt_o(clr), .cnt_wr_o(cnt_wr),
    .cnt_wr_idx_o(cnt_idx), .cnt_wr_data_o(cnt_data), .save_req_o(save)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic begin_xfer(); @(negedge clk); start = 1; @(negedge clk); start = 0; endtask
  task automatic put(input logic [7:0] d); @(negedge clk); wr = 1; wdata = d; @(negedge clk); wr = 0; endtask
  task automatic write_at(input logic [7:0] a, input logic [7:0] d); begin_xfer(); put(a); put(d); endtask
  task automatic read_at(input logic [7:0] a, output logic [7:0] d); begin_xfer(); put(a); #1 d = rdata; endtask
  task automatic pull(output logic [7:0] d); @(negedge clk); #1 d = rdata; rd = 1; @(negedge clk); rd = 0; endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) tick(); rst_n = 1; tick();
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    read_at(8'h00, d); chk("R2 cfg after reset", d, 8'h00);
    chk("R4 wd after reset", wd, 0);
    chk("R5 wmd after reset", wmd, 0);
    chk("R6 clr after reset", clr, 0);
    chk("R9 save after reset", save, 0);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    begin_xfer(); put(8'h0B); put(8'h11); put(8'h22); put(8'h33);
    begin_xfer(); put(8'h0B);
    pull(d); chk("R1 seq read 0", d, 8'h11);
    pull(d); chk("R1 seq read 1", d, 8'h22);
    pull(d); chk("R1 seq read 2", d, 8'h33);
    begin_xfer(); put(8'h14); put(8'h5A); put(8'h77);
    read_at(8'h14, d); chk("R10 last user byte", d, 8'h5A);
    read_at(8'h15, d); chk("R10 unmapped reads zero", d, 8'h00);
    begin_xfer(); put(8'h1F); pull(d); #1 chk("R1 wrap to 00 shows cfg", rdata, 8'h00);
  endtask

  task automatic t_alarm();
    begin_xfer(); put(8'h01); put(8'h78); put(8'h56); put(8'h34); put(8'h12);
    chk("R10 alarm LSB first", alarm, 32'h1234_5678);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    af = 1; evc = 17'h1_0000;
    write_at(8'h00, 8'hFF); read_at(8'h00, d);
    chk("R2 cfg writable bits", d, 8'h4F);
    chk("R2 aos/ap out", {aos, ap}, 2'b11);
    write_at(8'h00, 8'h00); read_at(8'h00, d);
    chk("R2 cfg clear", d, 8'h41);
  endtask

  task automatic t_counters();
    logic [7:0] d;
    etc = 32'hA1B2_C3D4; evc = 17'h1_5566;
    read_at(8'h05, d); chk("R8 etc byte0", d, 8'hD4);
    read_at(8'h08, d); chk("R8 etc byte3", d, 8'hA1);
    read_at(8'h09, d); chk("R8 evc low", d, 8'h66);
    read_at(8'h0A, d); chk("R8 evc high", d, 8'h55);
    begin_xfer(); put(8'h06);
    @(negedge clk); wr = 1; wdata = 8'h99; #1;
    chk("R8 cnt_wr strobe", cnt_wr, 1);
    chk("R8 cnt_wr idx", cnt_idx, 1);
    chk("R8 cnt_wr data", cnt_data, 8'h99);
    @(negedge clk); wr = 0; #1;
    chk("R8 cnt_wr one cycle", cnt_wr, 0);
  endtask

  task automatic end_event(input string req, input logic exp);
    @(negedge clk); ev = 0;
    @(negedge clk); chk(req, save, exp);
    @(negedge clk); chk({req, " low after"}, save, 0);
  endtask

  task automatic t_dirty();
    ev = 1; tick();
    write_at(8'h0C, 8'h22);
    end_event("R9 same value no save", 0);
    ev = 1; tick();
    write_at(8'h0C, 8'h23);
    end_event("R9 changed value saves", 1);
    write_at(8'h0C, 8'h24);
    ev = 1; tick();
    end_event("R9 write outside event", 0);
  endtask

  task automatic t_reset_cmd();
    logic [7:0] d;
    write_at(8'h00, 8'h00);
    write_at(8'h1D, 8'h55); write_at(8'h1D, 8'h55);
    chk("R6 ignored with enable low", clr, 0);
    write_at(8'h00, 8'h04); read_at(8'h00, d);
    chk("R6 enable set", d, 8'h45);
    write_at(8'h1D, 8'h55); write_at(8'h1D, 8'h55);
    chk("R6 clr pulse", clr, 1);
    tick(); chk("R6 clr one cycle", clr, 0);
    read_at(8'h00, d); chk("R6 enable cleared", d, 8'h41);
    write_at(8'h00, 8'h0E); read_at(8'h00, d);
    chk("R6 cfg read-only", d, 8'h41);
    write_at(8'h1D, 8'h55); write_at(8'h1D, 8'h55);
    chk("R7 second reset no clr", clr, 0);
    tick(); chk("R7 second reset no clr later", clr, 0);
  endtask

  task automatic t_wd();
    logic [7:0] d;
    write_at(8'h1E, 8'hAA); write_at(8'h0B, 8'h00); write_at(8'h1E, 8'hAA);
    chk("R3 split by data write", wd, 0);
    write_at(8'h1E, 8'hAB); write_at(8'h1E, 8'hAB);
    chk("R3 wrong magic", wd, 0);
    write_at(8'h1E, 8'hAA);
    read_at(8'h05, d);
    write_at(8'h1E, 8'hAA);
    chk("R3 read and pointer byte do not cancel", wd, 1);
    read_at(8'h00, d); chk("R4 flag in cfg", d[5], 1);
    write_at(8'h01, 8'h00);
    chk("R4 alarm locked", alarm, 32'h1234_5678);
    begin_xfer(); put(8'h05);
    @(negedge clk); wr = 1; wdata = 8'h01; #1;
    chk("R4 counter write blocked", cnt_wr, 0);
    @(negedge clk); wr = 0;
  endtask

  task automatic t_wmd();
    logic [7:0] d;
    write_at(8'h0B, 8'h3C);
    write_at(8'h1F, 8'hF0); write_at(8'h1F, 8'hF0);
    chk("R5 memory lock set", wmd, 1);
    write_at(8'h0B, 8'h99); read_at(8'h0B, d);
    chk("R5 user byte unchanged", d, 8'h3C);
    chk("R5 lock persists", wmd, 1);
  endtask

  task automatic t_reset_under_wd();
    logic [7:0] d;
    do_reset(); af = 0; evc = 0;
    write_at(8'h00, 8'h04);
    write_at(8'h1E, 8'hAA); write_at(8'h1E, 8'hAA);
    write_at(8'h1D, 8'h55); write_at(8'h1D, 8'h55);
    chk("R11 no clr under wd", clr, 0);
    tick(); chk("R11 no clr later", clr, 0);
    read_at(8'h00, d); chk("R11 enable cleared", d, 8'h20);
    write_at(8'h00, 8'h0E); read_at(8'h00, d);
    chk("R11 cfg read-only", d, 8'h20);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_pointer();
    t_alarm();
    t_cfg();
    t_counters();
    t_dirty();
    t_reset_cmd();
    t_wd();
    t_wmd();
    t_reset_under_wd();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule